// File: doc/BRIEF.md
# Set-Associative Cache with LRU Replacement

This block is the lookup and bookkeeping core of a set-associative cache. It is made of several direct-mapped ways that are looked up in parallel. Each way holds a tag, a valid bit and a dirty bit for every line, plus a word store addressed by line and sector. Per line, a shared history keeps the ways in order from least to most recently used. A lookup is combinational. The requested address is split into tag, line and sector. The per-way match bits are ORed into `hit`, and the matching word is steered to `rdata`.

Writes, tag updates and valid updates never pick a way from the address. They go only to the way held in a one-hot way-select register, which is loaded on every read strobe. On a hit it loads the hitting way. On a miss it loads the way the history names as least recently used. The victim dirty flag and the victim address come from that same predicted way. The surrounding controller can therefore issue a read and inspect the eviction candidate, write back if needed, and then refill through the write strobes. The refill lands in the selected way.

History updates are held for one read in a pending register and written back on the following read. Back-to-back reads of the same line use the pending copy.

Top module: `sac_top`

## Requirements
- R1: The address splits as tag in the top `ADDR_W-LINE_W-SECT_W` bits, line index in the next `LINE_W` bits and sector in the low `SECT_W` bits. `hit` is high in the same cycle when some way holds a set valid bit and an equal tag for that line.
- R2: On a hit, `rdata` is the word stored at the addressed line and sector in the hitting way. On a miss `rdata` is zero.
- R3: Data, tag and valid writes change only the way named by the one-hot way-select register. A data write updates byte `j` (bits `8j+7:8j`) of the addressed word only when `byte_en[j]` is set.
- R4: A data write with at least one byte enabled sets the dirty bit of the addressed line in the selected way. A data write with no byte enabled leaves the dirty bit unchanged. A cycle with both `tag_we` and `valid_we` clears that dirty bit, and this clear takes precedence over the set.
- R5: `victim_dirty` and `victim_addr` describe the predicted way: the hitting way on a hit, and the least recently used way on a miss. `victim_addr` is the stored tag, then the line index, then zeros in the sector bits.
- R6: When `rd_stb` is high, the way-select register loads the predicted way at the next edge. Otherwise it keeps its value. It is always one-hot.
- R7: On a read strobe, the accessed way becomes most recently used in that line's history. The accessed way is the hitting way, or the predicted victim on a miss. After reset or clear, every line's least-to-most order is way 0, 1, 2, and so on. Lines are independent of each other.
- R8: A read strobe that hits while `lru_demote` is high makes the hitting way least recently used instead.
- R9: Reset and `clr` clear all valid and dirty bits, restore every line's history order, and set the way-select register to way 0. Stored tags and data are kept.
- R10: Two read strobes in consecutive cycles on the same line see each other's history update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Access address |
| wdata | input | 8*BYTES | Write data |
| byte_en | input | BYTES | Per-byte write enables |
| data_we | input | 1 | Data write strobe for the selected way |
| valid_we | input | 1 | Valid-bit write strobe for the selected way |
| valid_in | input | 1 | Value written to the valid bit |
| tag_we | input | 1 | Tag write strobe for the selected way |
| rd_stb | input | 1 | Read strobe: updates history and the way-select register |
| clr | input | 1 | Synchronous clear of valid, dirty, history and way select |
| lru_demote | input | 1 | With a hitting read, place the hit way at the LRU end |
| hit | output | 1 | Lookup hit |
| rdata | output | 8*BYTES | Read data from the hitting way |
| victim_dirty | output | 1 | Dirty bit of the predicted way's line |
| victim_addr | output | ADDR_W | Eviction address of the predicted way |

## Verification
`hit`, `rdata`, `victim_dirty` and `victim_addr` are combinational. They are due in the same cycle the address is presented, so the bench drives inputs just after a falling edge and samples a moment later. Writes, history moves and way-select loads take effect at the next rising edge, and they are seen on the outputs from the following falling edge onward. That is why every check of an update is made one stimulus step after the strobe. History and way-select state is observed only through `victim_addr` on a later miss or hit, worked out by hand from the LRU order the requirements define.

// File: rtl/sac_pkg.sv
package sac_pkg;
    // Where a touched way is placed in a line's history order
    typedef enum logic {
        PLACE_MRU = 1'b0,
        PLACE_LRU = 1'b1
    } place_e;
endpackage

// File: rtl/sac_ohmux.sv
module sac_ohmux #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] din,
    output logic [W-1:0]   dout
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | (din[i*W +: W] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/sac_way.sv
module sac_way #(
    parameter int TAG_W  = 4,
    parameter int LINE_W = 2,
    parameter int SECT_W = 2,
    parameter int BYTES  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic [TAG_W+LINE_W+SECT_W-1:0]  addr,
    input  logic [8*BYTES-1:0]              wdata,
    input  logic [BYTES-1:0]                byte_en,
    input  logic                            data_we,
    input  logic                            valid_we,
    input  logic                            valid_in,
    input  logic                            tag_we,
    output logic                            hit,
    output logic [8*BYTES-1:0]              rdata,
    output logic                            dirty,
    output logic [TAG_W+LINE_W+SECT_W-1:0]  ev_addr
);
    localparam int ADDR_W = TAG_W + LINE_W + SECT_W;
    localparam int LINES  = 1 << LINE_W;
    localparam int WORDS  = 1 << (LINE_W + SECT_W);
    localparam int DATA_W = 8 * BYTES;

    typedef struct packed {
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0]             valid;
        logic [LINES-1:0]             dirty;
        logic [WORDS-1:0][DATA_W-1:0] data;
    } way_state_t;

    way_state_t s_d, s_q;

    logic [LINE_W-1:0]        line_idx;
    logic [LINE_W+SECT_W-1:0] word_idx;
    logic [TAG_W-1:0]         tag_in;

    assign line_idx = addr[SECT_W +: LINE_W];
    assign word_idx = addr[LINE_W+SECT_W-1:0];
    assign tag_in   = addr[ADDR_W-1 -: TAG_W];

    always_comb begin
        s_d = s_q;
        if (data_we) begin
            for (int j = 0; j < BYTES; j++) begin
                if (byte_en[j]) s_d.data[word_idx][8*j +: 8] = wdata[8*j +: 8];
            end
            if (|byte_en) s_d.dirty[line_idx] = 1'b1;
        end
        if (tag_we)   s_d.tag[line_idx]   = tag_in;
        if (valid_we) s_d.valid[line_idx] = valid_in;
        if (tag_we && valid_we) s_d.dirty[line_idx] = 1'b0;
        if (clr) begin
            s_d.valid = '0;
            s_d.dirty = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit     = s_q.valid[line_idx] && (s_q.tag[line_idx] == tag_in);
    assign rdata   = s_q.data[word_idx];
    assign dirty   = s_q.dirty[line_idx];
    assign ev_addr = {s_q.tag[line_idx], line_idx, {SECT_W{1'b0}}};
endmodule

// File: rtl/sac_lru.sv
module sac_lru
    import sac_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int LINE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd,
    input  logic [LINE_W-1:0] line,
    input  logic              hit,
    input  logic [WAYS-1:0]   hit_vec,
    input  logic              demote,
    output logic [WAYS-1:0]   victim_oh
);
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LINES = 1 << LINE_W;

    typedef logic [WAYS-1:0][IDX_W-1:0] order_t;

    typedef struct packed {
        logic [LINES-1:0][WAYS-1:0][IDX_W-1:0] store;
        order_t                                cur;
        logic [LINE_W-1:0]                     cur_line;
    } lru_state_t;

    function automatic order_t init_order();
        order_t o;
        for (int i = 0; i < WAYS; i++) o[i] = IDX_W'(i);
        return o;
    endfunction

    lru_state_t s_d, s_q;
    order_t     order, new_order;
    logic [IDX_W-1:0] hit_idx, target;
    place_e     place;
    int         pos;

    // Pending copy overrides the store for the line touched last
    assign order = (line == s_q.cur_line) ? s_q.cur : s_q.store[line];

    always_comb begin
        victim_oh = '0;
        victim_oh[order[0]] = 1'b1;
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        target = hit ? hit_idx : order[0];
        place  = (hit && demote) ? PLACE_LRU : PLACE_MRU;
        pos    = 0;
        for (int i = 0; i < WAYS; i++) begin
            if (order[i] == target) pos = i;
        end
        new_order = order;
        if (place == PLACE_MRU) begin
            for (int i = 0; i < WAYS - 1; i++) begin
                new_order[i] = (i < pos) ? order[i] : order[i+1];
            end
            new_order[WAYS-1] = target;
        end else begin
            new_order[0] = target;
            for (int i = 1; i < WAYS; i++) begin
                new_order[i] = (i <= pos) ? order[i-1] : order[i];
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (clr) begin
            for (int l = 0; l < LINES; l++) s_d.store[l] = init_order();
            s_d.cur      = init_order();
            s_d.cur_line = '0;
        end else if (rd) begin
            s_d.store[s_q.cur_line] = s_q.cur;
            s_d.cur      = new_order;
            s_d.cur_line = line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) s_q.store[l] <= init_order();
            s_q.cur      <= init_order();
            s_q.cur_line <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sac_top.sv
module sac_top #(
    parameter int ADDR_W = 8,
    parameter int LINE_W = 2,
    parameter int SECT_W = 2,
    parameter int BYTES  = 2,
    parameter int WAYS   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [8*BYTES-1:0]  wdata,
    input  logic [BYTES-1:0]    byte_en,
    input  logic                data_we,
    input  logic                valid_we,
    input  logic                valid_in,
    input  logic                tag_we,
    input  logic                rd_stb,
    input  logic                clr,
    input  logic                lru_demote,
    output logic                hit,
    output logic [8*BYTES-1:0]  rdata,
    output logic                victim_dirty,
    output logic [ADDR_W-1:0]   victim_addr
);
    localparam int TAG_W  = ADDR_W - LINE_W - SECT_W;
    localparam int DATA_W = 8 * BYTES;

    typedef struct packed {
        logic [WAYS-1:0] way_sel;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [WAYS-1:0]        hit_vec, dirty_vec, victim_oh, next_sel, way_sel_q;
    logic [WAYS*DATA_W-1:0] rdata_flat;
    logic [WAYS*ADDR_W-1:0] evaddr_flat;

    assign way_sel_q = s_q.way_sel;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        sac_way #(
            .TAG_W (TAG_W),
            .LINE_W(LINE_W),
            .SECT_W(SECT_W),
            .BYTES (BYTES)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .addr    (addr),
            .wdata   (wdata),
            .byte_en (byte_en & {BYTES{s_q.way_sel[g]}}),
            .data_we (data_we  & s_q.way_sel[g]),
            .valid_we(valid_we & s_q.way_sel[g]),
            .valid_in(valid_in),
            .tag_we  (tag_we   & s_q.way_sel[g]),
            .hit     (hit_vec[g]),
            .rdata   (rdata_flat[g*DATA_W +: DATA_W]),
            .dirty   (dirty_vec[g]),
            .ev_addr (evaddr_flat[g*ADDR_W +: ADDR_W])
        );
    end

    sac_lru #(
        .WAYS  (WAYS),
        .LINE_W(LINE_W)
    ) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .rd       (rd_stb),
        .line     (addr[SECT_W +: LINE_W]),
        .hit      (hit),
        .hit_vec  (hit_vec),
        .demote   (lru_demote),
        .victim_oh(victim_oh)
    );

    assign hit      = |hit_vec;
    assign next_sel = hit ? hit_vec : victim_oh;

    sac_ohmux #(.W(DATA_W), .N(WAYS)) u_mux_data (
        .sel(hit_vec), .din(rdata_flat), .dout(rdata)
    );

    sac_ohmux #(.W(1), .N(WAYS)) u_mux_dirty (
        .sel(next_sel), .din(dirty_vec), .dout(victim_dirty)
    );

    sac_ohmux #(.W(ADDR_W), .N(WAYS)) u_mux_ev (
        .sel(next_sel), .din(evaddr_flat), .dout(victim_addr)
    );

    always_comb begin
        s_d = s_q;
        if (clr)         s_d.way_sel = WAYS'(1);
        else if (rd_stb) s_d.way_sel = next_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.way_sel <= WAYS'(1);
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
    parameter int WAYS   = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              rd_stb,
    input logic              hit,
    input logic [DATA_W-1:0] rdata,
    input logic [WAYS-1:0]   way_sel_q,
    input logic [WAYS-1:0]   next_sel,
    input logic [WAYS-1:0]   hit_vec
);
    assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(way_sel_q));

    assert_sel_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !clr) |=> (way_sel_q == $past(next_sel)));

    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !clr) |=> $stable(way_sel_q));

    assert_clear_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (way_sel_q == WAYS'(1)));

    assert_hit_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (next_sel == hit_vec));

    assert_miss_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> $onehot(next_sel));

    assert_miss_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (rdata == '0));
endmodule

bind sac_top sac_checker #(
    .WAYS  (WAYS),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .rd_stb   (rd_stb),
    .hit      (hit),
    .rdata    (rdata),
    .way_sel_q(way_sel_q),
    .next_sel (next_sel),
    .hit_vec  (hit_vec)
);

// File: tb/sim_sac_top.sv
module sim_sac_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  byte_en = '0;
    logic        data_we = 1'b0, valid_we = 1'b0, valid_in = 1'b0, tag_we = 1'b0;
    logic        rd_stb = 1'b0, clr = 1'b0, lru_demote = 1'b0;
    logic        hit, victim_dirty;
    logic [15:0] rdata;
    logic [7:0]  victim_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    sac_top u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .byte_en(byte_en),
        .data_we(data_we), .valid_we(valid_we), .valid_in(valid_in), .tag_we(tag_we),
        .rd_stb(rd_stb), .clr(clr), .lru_demote(lru_demote), .hit(hit), .rdata(rdata),
        .victim_dirty(victim_dirty), .victim_addr(victim_addr)
    );

    always #10 clk = ~clk;

    // Address on line 1: tag in [7:4], line 01 in [3:2], sector in [1:0]
    function automatic logic [7:0] a1(input int t, input int sec);
        return 8'((t << 4) | 4 | sec);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        data_we = 0; valid_we = 0; valid_in = 0; tag_we = 0;
        rd_stb = 0; clr = 0; lru_demote = 0; byte_en = '0;
    endtask

    task automatic show(input logic [7:0] a);
        idle();
        addr = a;
        #1;
    endtask

    task automatic rd_op(input logic [7:0] a, input bit dem);
        idle();
        addr = a; rd_stb = 1; lru_demote = dem;
        tick();
        idle();
    endtask

    task automatic refill(input logic [7:0] a, input logic [15:0] d);
        idle();
        addr = a; wdata = d; byte_en = 2'b11;
        data_we = 1; tag_we = 1; valid_we = 1; valid_in = 1;
        tick();
        idle();
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
        idle();
        addr = a; wdata = d; byte_en = be; data_we = 1;
        tick();
        idle();
    endtask

    task automatic t_reset();
        show(a1(1, 0));
        check("R9 reset hit", hit, 0);
        check("R2 reset rdata", rdata, 0);
        check("R9 reset dirty", victim_dirty, 0);
        check("R5 reset victim_addr", victim_addr, 8'h04);
    endtask

    // Misses on line 1 pick ways 0,1,2,3 in turn (R7)
    task automatic t_fill();
        for (int t = 1; t <= 4; t++) begin
            show(a1(t, 0));
            check("R1 fill miss", hit, 0);
            rd_op(a1(t, 0), 0);
            refill(a1(t, 0), 16'hA000 + 16'(t));
        end
        for (int t = 1; t <= 4; t++) begin
            show(a1(t, 0));
            check("R1 hit after fill", hit, 1);
            check("R2 rdata after fill", rdata, 16'hA000 + 16'(t));
            check("R5 hit-way victim_addr", victim_addr, a1(t, 0));
        end
        show(8'h78);
        check("R7 other line untouched", victim_addr, 8'h08);
    endtask

    // Order [0,1,2,3] -> hit w0 -> [1,2,3,0] -> hit w2 -> [1,3,0,2]
    task automatic t_forward();
        idle(); addr = a1(1, 0); rd_stb = 1; tick();
        addr = a1(3, 0); rd_stb = 1; tick();
        show(a1(6, 0));
        check("R10 back-to-back LRU victim", victim_addr, 8'h24);
        check("R5 victim clean", victim_dirty, 0);
    endtask

    // way_sel = way 2 (tag 3) from last read
    task automatic t_bytes();
        wr(a1(3, 0), 16'h5566, 2'b01);
        show(a1(3, 0));
        check("R3 byte lane write", rdata, 16'hA066);
        check("R4 dirty set", victim_dirty, 1);
        show(a1(1, 0));
        check("R3 other way unchanged", rdata, 16'hA001);
        check("R4 other way clean", victim_dirty, 0);
        rd_op(a1(4, 0), 0);              // order [1,0,2,3], sel way 3
        wr(a1(4, 0), 16'hFFFF, 2'b00);
        show(a1(4, 0));
        check("R3 no byte enabled", rdata, 16'hA004);
        check("R4 no byte no dirty", victim_dirty, 0);
    endtask

    // Demote way 2 to LRU: [2,1,0,3]
    task automatic t_demote();
        rd_op(a1(3, 0), 1);
        show(a1(7, 0));
        check("R8 demoted way is victim", victim_addr, 8'h34);
        check("R5 dirty victim on miss", victim_dirty, 1);
        rd_op(a1(7, 0), 0);              // sel way 2
        refill(a1(7, 0), 16'hB007);
        show(a1(7, 0));
        check("R1 refilled hit", hit, 1);
        check("R2 refilled data", rdata, 16'hB007);
        check("R4 refill clears dirty", victim_dirty, 0);
        show(a1(3, 0));
        check("R1 evicted tag misses", hit, 0);
    endtask

    task automatic t_clear();
        idle(); clr = 1; tick(); idle();
        show(a1(7, 0));
        check("R9 clear drops valid", hit, 0);
        check("R9 clear resets LRU", victim_addr, 8'h14);
        check("R9 clear drops dirty", victim_dirty, 0);
        tick(); tick();                  // no read: select must hold (R6)
        refill(a1(9, 0), 16'hC009);
        show(a1(9, 0));
        check("R9 refill lands after clear", hit, 1);
        check("R2 data after clear", rdata, 16'hC009);
        show(a1(9, 2));
        check("R2 sector select", rdata, 16'h0000);
        show(a1(5, 0));
        check("R6 select was way 0", victim_addr, a1(9, 0));
        show(a1(2, 0));
        check("R9 other way invalid", hit, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_fill();
        t_forward();
        t_bytes();
        t_demote();
        t_clear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule